// File: doc/BRIEF.md
# Command and Control-Block Validator

This block screens every start request that software issues to a communications attachment before any data moves. A request arrives as one 32-bit immediate control word that names a command, a device and the byte address of an eight-word control block in processor storage. The block decodes the word first. A request that is malformed at that level is refused at once with a delayed command reject, and no storage read is made.

A request that passes decoding makes the block fetch control-block words 0, 6 and 7 through a simple word-read port. Word 0 holds the control flags and the storage key, word 6 the byte count and word 7 the data address. The fields are then checked against the rules of the command and of the selected line protocol. The outcome is exactly one single-cycle pulse: reject, specification check or accept. On accept, the key, count and address are presented for the transfer logic that follows. A busy flag keeps new requests out while a fetch is in progress.

Top module: `cbv_validator`

## Requirements
- R1: `cmd_word[31:24]` is the command, `cmd_word[23:16]` the device address and `cmd_word[15:0]` the control-block byte address. A request is taken when `cmd_valid` is high and `busy` is low.
- R2: Only the command codes 0x40 (start), 0x42 (status start), 0x44 (microcode modify), 0x48 (diagnostic 1) and 0x49 (diagnostic 2) are valid. Any other code gives `cmd_reject` one cycle after the request is taken, and no read is issued.
- R3: An odd control-block address (bit 0 set) gives `cmd_reject` one cycle after the request is taken.
- R4: A device address other than 0 or 1 gives `cmd_reject`. A status start or a microcode modify sent to device 1 also gives `cmd_reject`. Start and the diagnostics are valid on both devices.
- R5: A request that passes decoding makes `busy` high and issues exactly three reads, one every other cycle, at byte addresses base, base+12 and base+14 (words 0, 6, 7). Read data is taken the cycle after `rd_en`. The result pulse comes 8 cycles after the request is taken, in the same cycle that `busy` falls.
- R6: For a status start, the following conditions give `spec_check`: the input flag (word 0 bit 15) is clear; the data address (word 7) is odd; or the byte count (word 6) is not 8 or 12 with `mode_bsc`=0, or not 6 or 10 with `mode_bsc`=1.
- R7: For diagnostic 1 the byte count must be 0x11, and for diagnostic 2 it must be 2. Both diagnostics also need the input flag set, an even data address and word 0 bits 10:3 all zero. Any violation gives `spec_check`.
- R8: For start, the operation bits are word 0 bit 14 receive, bit 13 transmit, bit 12 disable and bit 11 enable. More than one of them set gives `spec_check`, and so does receive or transmit with a zero byte count. The microcode modify has no field checks.
- R9: Each taken request gives exactly one single-cycle pulse among `cmd_reject`, `spec_check` and `start_accept`. `status_byte` becomes 0x02 with a reject, 0x08 with a specification check and 0x00 with an accept, and holds that value until the next result.
- R10: With `start_accept`, `acc_key` shows word 0 bits 2:0, `acc_count` shows word 6 and `acc_addr` shows word 7.
- R11: `cmd_valid` while `busy` is high is ignored and yields no result pulse of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bsc | input | 1 | Line protocol select: 0 bit-oriented, 1 character-oriented |
| cmd_valid | input | 1 | Request strobe |
| cmd_word | input | 32 | Immediate control word |
| busy | output | 1 | Control-block fetch in progress |
| rd_en | output | 1 | Storage word read request |
| rd_addr | output | 16 | Byte address of the word read |
| rd_data | input | 16 | Read data, valid the cycle after rd_en |
| cmd_reject | output | 1 | Delayed command reject pulse |
| spec_check | output | 1 | Control-block specification check pulse |
| start_accept | output | 1 | Request accepted pulse |
| status_byte | output | 8 | Status of the last result |
| acc_key | output | 3 | Storage key of the accepted block |
| acc_count | output | 16 | Byte count of the accepted block |
| acc_addr | output | 16 | Data address of the accepted block |

## Verification
The hardest case to reach is a request that arrives while a fetch is still running. It has to line up with the middle of the seven-cycle read sequence, and it must leave no trace. The bench places such a request, with a code that would be rejected, at a fixed cycle inside a valid fetch. It then watches that only the first request's result appears and that nothing follows it. Random requests are weighted towards valid codes, even addresses and the legal byte counts, so the field checks are actually reached rather than cut off by decode rejects. Directed cases sit on each legal count and on its nearest illegal neighbour for both protocols.

// File: rtl/cbv_pkg.sv
package cbv_pkg;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_START,
        CL_STATUS,
        CL_MODIFY,
        CL_DIAG1,
        CL_DIAG2
    } cmd_class_e;

    localparam logic [7:0] CODE_START  = 8'h40;
    localparam logic [7:0] CODE_STATUS = 8'h42;
    localparam logic [7:0] CODE_MODIFY = 8'h44;
    localparam logic [7:0] CODE_DIAG1  = 8'h48;
    localparam logic [7:0] CODE_DIAG2  = 8'h49;

    // control word (block word 0) field positions
    localparam int IN_FLAG_BIT = 15;
    localparam int OP_RX_BIT   = 14;
    localparam int OP_TX_BIT   = 13;
    localparam int OP_DIS_BIT  = 12;
    localparam int OP_EN_BIT   = 11;
    localparam int RSV_HI      = 10;
    localparam int RSV_LO      = 3;
    localparam int KEY_HI      = 2;
    localparam int KEY_LO      = 0;
    localparam int KEY_W       = KEY_HI - KEY_LO + 1;

    localparam logic [7:0] STAT_NONE   = 8'h00;
    localparam logic [7:0] STAT_REJECT = 8'h02;
    localparam logic [7:0] STAT_SPEC   = 8'h08;

endpackage

// File: rtl/cbv_cmd_decode.sv
module cbv_cmd_decode
    import cbv_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int DEV_W   = 8,
    parameter int CBA_W   = 16,
    parameter int NUM_DEV = 2
) (
    input  logic [CODE_W-1:0] code,
    input  logic [DEV_W-1:0]  dev,
    input  logic [CBA_W-1:0]  cb_addr,
    output cmd_class_e        cls,
    output logic              reject
);
    localparam logic [DEV_W-1:0] DEV_LIMIT = DEV_W'(NUM_DEV);
    localparam logic [DEV_W-1:0] DEV_ONE   = DEV_W'(1);

    logic bad_dev;
    logic dev1_only0;

    always_comb begin
        unique case (8'(code))
            CODE_START:  cls = CL_START;
            CODE_STATUS: cls = CL_STATUS;
            CODE_MODIFY: cls = CL_MODIFY;
            CODE_DIAG1:  cls = CL_DIAG1;
            CODE_DIAG2:  cls = CL_DIAG2;
            default:     cls = CL_NONE;
        endcase
        bad_dev    = (dev >= DEV_LIMIT);
        dev1_only0 = (dev == DEV_ONE) && (cls == CL_STATUS || cls == CL_MODIFY);
        reject     = (cls == CL_NONE) || cb_addr[0] || bad_dev || dev1_only0;
    end
endmodule

// File: rtl/cbv_fetch_seq.sv
module cbv_fetch_seq #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int CNT_IDX = 6,
    parameter int ADR_IDX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] w_ctl,
    output logic [DATA_W-1:0] w_cnt,
    output logic [DATA_W-1:0] w_adr
);
    localparam int NWORDS = 3;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT, PH_DONE} phase_e;

    typedef struct packed {
        phase_e                         phase;
        logic [IDX_W-1:0]               idx;
        logic [ADDR_W-1:0]              base;
        logic [NWORDS-1:0][DATA_W-1:0]  words;
    } seq_s;

    seq_s s_q, s_d;

    // block word number fetched in each slot
    logic [NWORDS-1:0][ADDR_W-1:0] slot_off;
    generate
        for (genvar g = 0; g < NWORDS; g++) begin : g_slot
            localparam int WNUM = (g == 0) ? 0 : ((g == 1) ? CNT_IDX : ADR_IDX);
            assign slot_off[g] = ADDR_W'(WNUM * 2);
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_REQ;
                    s_d.idx   = '0;
                    s_d.base  = base;
                end
            end
            PH_REQ: s_d.phase = PH_WAIT;
            PH_WAIT: begin
                s_d.words[s_q.idx] = rd_data;
                if (s_q.idx == LAST_IDX) begin
                    s_d.phase = PH_DONE;
                end else begin
                    s_d.phase = PH_REQ;
                    s_d.idx   = s_q.idx + IDX_W'(1);
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_en   = (s_q.phase == PH_REQ);
    assign rd_addr = s_q.base + slot_off[s_q.idx];
    assign busy    = (s_q.phase != PH_IDLE);
    assign done    = (s_q.phase == PH_DONE);
    assign w_ctl   = s_q.words[0];
    assign w_cnt   = s_q.words[1];
    assign w_adr   = s_q.words[2];
endmodule

// File: rtl/cbv_field_check.sv
module cbv_field_check
    import cbv_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int STAT_SDLC_A = 8,
    parameter int STAT_SDLC_B = 12,
    parameter int STAT_BSC_A  = 6,
    parameter int STAT_BSC_B  = 10,
    parameter int DIAG1_CNT   = 17,
    parameter int DIAG2_CNT   = 2
) (
    input  cmd_class_e        cls,
    input  logic              mode_bsc,
    input  logic [DATA_W-1:0] w_ctl,
    input  logic [DATA_W-1:0] w_cnt,
    input  logic [DATA_W-1:0] w_adr,
    output logic              spec_err
);
    logic       in_flag;
    logic [3:0] ops;
    logic       rsv_set;
    logic       odd_adr;
    logic       cnt_zero;
    logic       stat_cnt_ok;
    logic       in_side_ok;

    always_comb begin
        in_flag  = w_ctl[IN_FLAG_BIT];
        ops      = {w_ctl[OP_RX_BIT], w_ctl[OP_TX_BIT], w_ctl[OP_DIS_BIT], w_ctl[OP_EN_BIT]};
        rsv_set  = |w_ctl[RSV_HI:RSV_LO];
        odd_adr  = w_adr[0];
        cnt_zero = (w_cnt == '0);
        if (mode_bsc) begin
            stat_cnt_ok = (w_cnt == DATA_W'(STAT_BSC_A)) || (w_cnt == DATA_W'(STAT_BSC_B));
        end else begin
            stat_cnt_ok = (w_cnt == DATA_W'(STAT_SDLC_A)) || (w_cnt == DATA_W'(STAT_SDLC_B));
        end
        in_side_ok = in_flag && !odd_adr;

        unique case (cls)
            CL_START:  spec_err = ($countones(ops) > 1) ||
                                  ((ops[3] || ops[2]) && cnt_zero);
            CL_STATUS: spec_err = !in_side_ok || !stat_cnt_ok;
            CL_DIAG1:  spec_err = !in_side_ok || rsv_set || (w_cnt != DATA_W'(DIAG1_CNT));
            CL_DIAG2:  spec_err = !in_side_ok || rsv_set || (w_cnt != DATA_W'(DIAG2_CNT));
            default:   spec_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbv_validator.sv
module cbv_validator
    import cbv_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int DEV_W   = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int NUM_DEV = 2,
    parameter int CNT_IDX = 6,
    parameter int ADR_IDX = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_bsc,
    input  logic                     cmd_valid,
    input  logic [CODE_W+DEV_W+ADDR_W-1:0] cmd_word,
    output logic                     busy,
    output logic                     rd_en,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic [DATA_W-1:0]        rd_data,
    output logic                     cmd_reject,
    output logic                     spec_check,
    output logic                     start_accept,
    output logic [7:0]               status_byte,
    output logic [KEY_W-1:0]         acc_key,
    output logic [DATA_W-1:0]        acc_count,
    output logic [ADDR_W-1:0]        acc_addr
);
    localparam int CW_W    = CODE_W + DEV_W + ADDR_W;
    localparam int CODE_LO = CW_W - CODE_W;
    localparam int DEV_LO  = ADDR_W;

    typedef struct packed {
        logic              rej;
        logic              spec;
        logic              acc;
        logic [7:0]        stat;
        logic [KEY_W-1:0]  key;
        logic [DATA_W-1:0] cnt;
        logic [ADDR_W-1:0] adr;
        cmd_class_e        cls;
    } top_s;

    top_s t_q, t_d;

    cmd_class_e        dec_cls;
    logic              dec_reject;
    logic              take;
    logic              fetch_start;
    logic              fetch_busy;
    logic              fetch_done;
    logic [DATA_W-1:0] w_ctl, w_cnt, w_adr;
    logic              spec_err;

    cbv_cmd_decode #(
        .CODE_W (CODE_W),
        .DEV_W  (DEV_W),
        .CBA_W  (ADDR_W),
        .NUM_DEV(NUM_DEV)
    ) u_dec (
        .code   (cmd_word[CW_W-1:CODE_LO]),
        .dev    (cmd_word[CODE_LO-1:DEV_LO]),
        .cb_addr(cmd_word[ADDR_W-1:0]),
        .cls    (dec_cls),
        .reject (dec_reject)
    );

    assign take        = cmd_valid && !fetch_busy;
    assign fetch_start = take && !dec_reject;

    cbv_fetch_seq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_IDX(CNT_IDX),
        .ADR_IDX(ADR_IDX)
    ) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fetch_start),
        .base   (cmd_word[ADDR_W-1:0]),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .busy   (fetch_busy),
        .done   (fetch_done),
        .w_ctl  (w_ctl),
        .w_cnt  (w_cnt),
        .w_adr  (w_adr)
    );

    cbv_field_check #(
        .DATA_W(DATA_W)
    ) u_chk_fields (
        .cls     (t_q.cls),
        .mode_bsc(mode_bsc),
        .w_ctl   (w_ctl),
        .w_cnt   (w_cnt),
        .w_adr   (w_adr),
        .spec_err(spec_err)
    );

    always_comb begin
        t_d      = t_q;
        t_d.rej  = 1'b0;
        t_d.spec = 1'b0;
        t_d.acc  = 1'b0;
        if (fetch_done) begin
            if (spec_err) begin
                t_d.spec = 1'b1;
                t_d.stat = STAT_SPEC;
            end else begin
                t_d.acc  = 1'b1;
                t_d.stat = STAT_NONE;
                t_d.key  = w_ctl[KEY_HI:KEY_LO];
                t_d.cnt  = w_cnt;
                t_d.adr  = w_adr;
            end
        end else if (take) begin
            if (dec_reject) begin
                t_d.rej  = 1'b1;
                t_d.stat = STAT_REJECT;
            end else begin
                t_d.cls = dec_cls;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q     <= '0;
            t_q.cls <= CL_NONE;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy         = fetch_busy;
    assign cmd_reject   = t_q.rej;
    assign spec_check   = t_q.spec;
    assign start_accept = t_q.acc;
    assign status_byte  = t_q.stat;
    assign acc_key      = t_q.key;
    assign acc_count    = t_q.cnt;
    assign acc_addr     = t_q.adr;
endmodule

// File: rtl/cbv_validator_chk.sv
module cbv_validator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       rd_en,
    input logic       cmd_reject,
    input logic       spec_check,
    input logic       start_accept,
    input logic [7:0] status_byte
);
    // R9: never more than one result at a time
    a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cmd_reject, spec_check, start_accept}) <= 1);

    // R9: status byte agrees with the pulse shown
    a_r9_stat_reject: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> status_byte == 8'h02);
    a_r9_stat_spec: assert property (@(posedge clk) disable iff (!rst_n)
        spec_check |-> status_byte == 8'h08);
    a_r9_stat_accept: assert property (@(posedge clk) disable iff (!rst_n)
        start_accept |-> status_byte == 8'h00);

    // R5: reads are spaced and only during a fetch
    a_r5_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    a_r5_read_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    // R5: end of a fetch always brings a field-check result
    a_r5_fetch_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (spec_check || start_accept));

    // R2: a decode reject never coincides with a fetch
    a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> !busy);
endmodule

bind cbv_validator cbv_validator_chk u_assert (.*);

// File: tb/cbv_validator_test.sv
module cbv_validator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_bsc = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        busy;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [15:0] rd_data = '0;
    logic        cmd_reject, spec_check, start_accept;
    logic [7:0]  status_byte;
    logic [2:0]  acc_key;
    logic [15:0] acc_count, acc_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cbv_validator uut (.*);

    // storage model: eight block words at mem_base
    logic [15:0] mem_w [8];
    logic [15:0] mem_base = '0;
    logic [15:0] rd_log [8];
    int          rd_n = 0;

    always @(posedge clk) begin
        if (rd_en) begin
            logic [15:0] off;
            off = rd_addr - mem_base;
            if (rd_n < 8) rd_log[rd_n] <= rd_addr;
            rd_n <= rd_n + 1;
            rd_data <= (off < 16) ? mem_w[off[3:1]] : 16'hDEAD;
        end
    end

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // 0 accept, 1 reject, 2 spec
    function automatic int expect_res(input logic [7:0] code, input logic [7:0] dev,
                                      input logic [15:0] cb, input logic [15:0] w0,
                                      input logic [15:0] cnt, input logic [15:0] adr,
                                      input logic bsc);
        bit known = (code == 8'h40) || (code == 8'h42) || (code == 8'h44) ||
                    (code == 8'h48) || (code == 8'h49);
        int nops;
        if (!known || cb[0] || dev > 1) return 1;
        if (dev == 1 && (code == 8'h42 || code == 8'h44)) return 1;
        nops = w0[14] + w0[13] + w0[12] + w0[11];
        case (code)
            8'h40: if (nops > 1 || ((w0[14] || w0[13]) && cnt == 0)) return 2;
            8'h42: begin
                if (!w0[15] || adr[0]) return 2;
                if (bsc && !(cnt == 6 || cnt == 10)) return 2;
                if (!bsc && !(cnt == 8 || cnt == 12)) return 2;
            end
            8'h48: if (!w0[15] || adr[0] || w0[10:3] != 0 || cnt != 16'h11) return 2;
            8'h49: if (!w0[15] || adr[0] || w0[10:3] != 0 || cnt != 2) return 2;
            default: ;
        endcase
        return 0;
    endfunction

    task automatic run_cmd(input logic [7:0] code, input logic [7:0] dev, input logic [15:0] cb,
                           input logic [15:0] w0, input logic [15:0] cnt, input logic [15:0] adr,
                           input string tag, input bit intrude);
        int exp_r, got_r, got_k, npulse;
        logic [7:0] got_stat;
        logic [2:0] got_key;
        logic [15:0] got_cnt, got_adr;
        for (int i = 0; i < 8; i++) mem_w[i] = 16'h5A00 + 16'(i);
        mem_w[0] = w0; mem_w[6] = cnt; mem_w[7] = adr;
        mem_base = cb;
        rd_n = 0;
        exp_r = expect_res(code, dev, cb, w0, cnt, adr, mode_bsc);
        got_r = -1; got_k = 0; npulse = 0;
        got_stat = 0; got_key = 0; got_cnt = 0; got_adr = 0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = {code, dev, cb};
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            if (intrude && k == 3) begin
                cmd_valid = 1'b1;
                cmd_word  = {8'hFF, 8'h00, 16'h0001};
            end else begin
                cmd_valid = 1'b0;
            end
            if (cmd_reject || spec_check || start_accept) begin
                npulse += cmd_reject + spec_check + start_accept;
                if (got_r < 0) begin
                    got_r = cmd_reject ? 1 : (spec_check ? 2 : 0);
                    got_k = k;
                    got_stat = status_byte; got_key = acc_key;
                    got_cnt = acc_count; got_adr = acc_addr;
                end
            end
            if (k < 12) @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk({tag, " result kind"}, got_r == exp_r, got_r, exp_r);
        chk("R9 single pulse", npulse == 1, npulse, 1);
        chk("R9 status byte", got_stat == ((exp_r == 1) ? 8'h02 : (exp_r == 2) ? 8'h08 : 8'h00),
            got_stat, (exp_r == 1) ? 2 : (exp_r == 2) ? 8 : 0);
        if (exp_r == 1) begin
            chk("R2 reject latency", got_k == 1, got_k, 1);
            chk("R2 no read on reject", rd_n == 0, rd_n, 0);
        end else begin
            chk("R5 result latency", got_k == 8, got_k, 8);
            chk("R5 read count", rd_n == 3, rd_n, 3);
            chk("R5 read word 0", rd_log[0] == cb, rd_log[0], cb);
            chk("R5 read word 6", rd_log[1] == cb + 16'd12, rd_log[1], cb + 16'd12);
            chk("R5 read word 7", rd_log[2] == cb + 16'd14, rd_log[2], cb + 16'd14);
        end
        if (exp_r == 0) begin
            chk("R10 key", got_key == w0[2:0], got_key, w0[2:0]);
            chk("R10 count", got_cnt == cnt, got_cnt, cnt);
            chk("R10 address", got_adr == adr, got_adr, adr);
        end
    endtask

    initial begin
        logic [7:0] codes [6];
        codes = '{8'h40, 8'h42, 8'h44, 8'h48, 8'h49, 8'h00};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R9 reset pulses", {cmd_reject, spec_check, start_accept} == 3'b000,
            {cmd_reject, spec_check, start_accept}, 0);
        chk("R1 reset busy", busy == 1'b0, busy, 0);
        chk("R5 reset rd_en", rd_en == 1'b0, rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset status", status_byte == 8'h00, status_byte, 0);

        // directed corners
        mode_bsc = 1'b0;
        run_cmd(8'h42, 0, 16'h0100, 16'h8005, 8,  16'h2000, "R6 sdlc 8", 0);
        run_cmd(8'h42, 0, 16'h0100, 16'h8005, 12, 16'h2000, "R6 sdlc 12", 0);
        run_cmd(8'h42, 0, 16'h0100, 16'h8005, 6,  16'h2000, "R6 sdlc 6", 0);
        run_cmd(8'h42, 0, 16'h0100, 16'h0005, 8,  16'h2000, "R6 no input flag", 0);
        run_cmd(8'h42, 0, 16'h0100, 16'h8005, 8,  16'h2001, "R6 odd data addr", 0);
        mode_bsc = 1'b1;
        run_cmd(8'h42, 0, 16'h0200, 16'h8001, 6,  16'h3000, "R6 bsc 6", 0);
        run_cmd(8'h42, 0, 16'h0200, 16'h8001, 10, 16'h3000, "R6 bsc 10", 0);
        run_cmd(8'h42, 0, 16'h0200, 16'h8001, 8,  16'h3000, "R6 bsc 8", 0);
        mode_bsc = 1'b0;
        run_cmd(8'h48, 1, 16'h0300, 16'h8007, 16'h11, 16'h0040, "R7 diag1 ok", 0);
        run_cmd(8'h48, 0, 16'h0300, 16'h8007, 16'h10, 16'h0040, "R7 diag1 count", 0);
        run_cmd(8'h48, 0, 16'h0300, 16'h8087, 16'h11, 16'h0040, "R7 diag1 reserved", 0);
        run_cmd(8'h49, 0, 16'h0300, 16'h8002, 2, 16'h0040, "R7 diag2 ok", 0);
        run_cmd(8'h49, 0, 16'h0300, 16'h0002, 2, 16'h0040, "R7 diag2 no flag", 0);
        run_cmd(8'h40, 0, 16'h0400, 16'h6000, 5, 16'h0041, "R8 rx and tx", 0);
        run_cmd(8'h40, 1, 16'h0400, 16'h4000, 0, 16'h0041, "R8 rx zero count", 0);
        run_cmd(8'h40, 0, 16'h0400, 16'h2000, 0, 16'h0041, "R8 tx zero count", 0);
        run_cmd(8'h40, 0, 16'h0400, 16'h0806, 0, 16'h0041, "R8 enable zero count", 0);
        run_cmd(8'h44, 0, 16'h0500, 16'hFFFF, 0, 16'h0001, "R8 modify unchecked", 0);
        run_cmd(8'h44, 1, 16'h0500, 16'h0000, 4, 16'h0000, "R4 modify dev1", 0);
        run_cmd(8'h42, 1, 16'h0500, 16'h8000, 8, 16'h0000, "R4 status dev1", 0);
        run_cmd(8'h40, 2, 16'h0500, 16'h4000, 4, 16'h0000, "R4 device 2", 0);
        run_cmd(8'h40, 0, 16'h0501, 16'h4000, 4, 16'h0000, "R3 odd block addr", 0);
        run_cmd(8'h41, 0, 16'h0500, 16'h4000, 4, 16'h0000, "R2 bad code", 0);
        // R11: rejectable request during the fetch is ignored
        run_cmd(8'h40, 0, 16'h0600, 16'h4003, 9, 16'h1234, "R11 ignored while busy", 1);
        // R1: fields taken from cmd_word positions (high block address)
        run_cmd(8'h40, 1, 16'hFFF0, 16'h1000, 7, 16'h0BEE, "R1 field layout", 0);

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [7:0]  code, dev;
            logic [15:0] cb, w0, cnt, adr;
            int sel;
            mode_bsc = n[7];
            sel  = int'($urandom_range(0, 5));
            code = (sel == 5) ? 8'($urandom) : codes[sel];
            sel  = int'($urandom_range(0, 9));
            dev  = (sel < 7) ? 8'h00 : (sel < 9) ? 8'h01 : 8'($urandom);
            cb   = 16'($urandom) & 16'hFFE0;
            if ($urandom_range(0, 9) == 0) cb[0] = 1'b1;
            w0   = 16'($urandom) & 16'h0007;
            sel  = int'($urandom_range(0, 5));
            if (sel < 4) w0[11 + sel] = 1'b1;
            else if (sel == 4) w0[14:11] = 4'($urandom);
            if ($urandom_range(0, 9) != 0) w0[15] = 1'b1;
            if ($urandom_range(0, 5) == 0) w0[10:3] = 8'($urandom);
            sel  = int'($urandom_range(0, 8));
            case (sel)
                0: cnt = 0;  1: cnt = 2;  2: cnt = 6;  3: cnt = 8;
                4: cnt = 10; 5: cnt = 12; 6: cnt = 16'h11;
                default: cnt = 16'($urandom);
            endcase
            adr  = 16'($urandom) & 16'hFFFE;
            if ($urandom_range(0, 7) == 0) adr[0] = 1'b1;
            run_cmd(code, dev, cb, w0, cnt, adr, "R2 R4 R6 R7 R8 random", 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule